// File: doc/BRIEF.md
# Infrared Receive Register Block

This block is the host side of a consumer-infrared receiver. It watches a demodulated infrared line (1 = carrier present, "pulse"; 0 = no carrier, "space"), measures every run of constant level in ticks of a fixed period, and turns each run into one byte. The bytes queue in a small FIFO that the host drains through a data register. Two status flags, one for new data and one for an idle timeout, can raise an interrupt line once the host sets the interrupt enable.

The host sees three byte registers at fixed offsets. Offset 0 is status: bit 7 is the interrupt enable, bit 1 is the idle-timeout flag and bit 0 is the data-available flag. Bits 3 and 2 are transmit-side flags that always read 0 because this block has no transmitter. Offset 1 is the receive data register. Offset 4 holds the idle limit in ticks in bits 6..0. Any other offset reads 0. The tick is a prescaled version of the system clock, with the divider as a parameter, so that one tick lasts 50 µs.

After reset the receiver is idle. The first pulse starts the first run, and a space that has lasted the idle limit closes the burst. The host reads the run bytes out one per read.

Top module: `ir_rx_regs`

## Requirements
- R1: Each run of constant input level becomes one byte when the level changes. Bit 7 holds the level (1 pulse, 0 space) and bits 6..0 hold the run length in ticks. One tick is TICK_DIV clock cycles.
- R2: A run longer than 127 ticks gives a byte with duration 127 and then continues counting from 1 in a new byte of the same level.
- R3: When a space reaches the idle limit T (offset 4, bits 6..0, reset value 20), the block pushes a space byte of duration T, sets status bit 1 and goes idle. While idle it records nothing until the next pulse. Space before the first pulse after reset is not recorded.
- R4: An idle limit of 0 disables the timeout, and long spaces are then split at 127 in the same way as pulses.
- R5: A read of offset 1 returns the oldest queued byte and removes it. A read while the queue is empty returns 0x00 and changes nothing.
- R6: The queue holds 32 bytes. A byte produced while the queue is full is dropped and the stored bytes stay intact.
- R7: Status bit 0 reads 1 exactly while the queue holds data.
- R8: Status bit 1 stays set while data is queued and clears when the host reads the last byte. Writing 1 to bits 1..0 while data is queued does not clear them, and writing 0 never clears them.
- R9: Status bit 7 is a read/write interrupt enable. Bits 6..2 always read 0 and ignore writes.
- R10: The irq output is high exactly when status bit 7 is set and any of status bits 3..0 is set.
- R11: After reset, status reads 0x00, offset 4 reads 20 (0x14) and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated infrared level, 1 = pulse |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; pops at offset 1 |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the 127-tick split boundary for both pulses and (with the timeout off) spaces. A coder that wrapped its counter would give a zero-duration byte or a byte of the wrong length there. It fills the queue past 32 entries: a design that overwrote on overflow would show later bytes at the head instead of the first 32 in order. It also attempts write-1-to-clear while data is still queued and checks that the timeout flag drops together with the last read. A design that cleared the flags eagerly or left them sticky would show up in the status value and in irq. A changed idle limit, a zero limit and the interrupt enable gating irq are each checked through exact byte values.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int DUR_W = 7;
  localparam logic [DUR_W-1:0] DUR_MAX = '1;

  localparam logic [2:0] OFS_STATUS = 3'd0;
  localparam logic [2:0] OFS_DATA   = 3'd1;
  localparam logic [2:0] OFS_LIMIT  = 3'd4;

  // sample byte: level in the top bit, duration below it
  function automatic logic [7:0] pack_sample(input logic lvl, input logic [DUR_W-1:0] dur);
    return {lvl, dur};
  endfunction

  // status byte: enable, three zero bits, tx finished, tx underrun, timeout, data
  function automatic logic [7:0] pack_status(input logic ie, input logic to, input logic rx);
    return {ie, 3'b000, 1'b0, 1'b0, to, rx};
  endfunction

  // saturating run-length step with split at the top value
  function automatic logic [DUR_W-1:0] run_step(input logic [DUR_W-1:0] run);
    return (run == DUR_MAX) ? DUR_W'(1) : run + DUR_W'(1);
  endfunction
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int DIV = 6250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/ir_run_coder.sv
module ir_run_coder
  import ir_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             lvl_in,
  input  logic [DUR_W-1:0] idle_lim,
  output logic             emit,
  output logic [7:0]       emit_byte,
  output logic             idle_evt
);
  logic             idle_q, idle_n;
  logic             cur_q, cur_n;
  logic [DUR_W-1:0] run_q, run_n;
  logic [7:0]       spc_q, spc_n;
  logic             limit_hit;

  assign limit_hit = (idle_lim != '0) && (spc_q >= {1'b0, idle_lim});

  always_comb begin
    idle_n = idle_q; cur_n = cur_q; run_n = run_q; spc_n = spc_q;
    emit = 1'b0; emit_byte = '0; idle_evt = 1'b0;
    if (tick) begin
      if (idle_q) begin
        if (lvl_in) begin
          idle_n = 1'b0; cur_n = 1'b1; run_n = DUR_W'(1); spc_n = '0;
        end
      end else if (lvl_in != cur_q) begin
        emit = 1'b1; emit_byte = pack_sample(cur_q, run_q);
        cur_n = lvl_in; run_n = DUR_W'(1);
        spc_n = lvl_in ? 8'd0 : 8'd1;
      end else if (!cur_q && limit_hit) begin
        emit = 1'b1; emit_byte = pack_sample(1'b0, run_q); idle_evt = 1'b1;
        idle_n = 1'b1; run_n = '0; spc_n = '0;
      end else begin
        if (run_q == DUR_MAX) begin
          emit = 1'b1; emit_byte = pack_sample(cur_q, DUR_MAX);
        end
        run_n = run_step(run_q);
        if (!cur_q && spc_q != 8'hff) spc_n = spc_q + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1; cur_q <= 1'b0; run_q <= '0; spc_q <= '0;
    end else begin
      idle_q <= idle_n; cur_q <= cur_n; run_q <= run_n; spc_q <= spc_n;
    end
  end
endmodule

// File: rtl/ir_sample_fifo.sv
module ir_sample_fifo #(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  output logic [7:0]    head,
  output logic          empty,
  output logic          full,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [LW-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == LW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? 8'h00 : mem[rd_ptr];
  assign level   = cnt_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + LW'(1);
        2'b01:   cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ir_rx_regs.sv
module ir_rx_regs
  import ir_rx_pkg::*;
#(
  parameter int TICK_DIV     = 6250,
  parameter int FIFO_DEPTH   = 32,
  parameter int IDLE_DEFAULT = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_in,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int LW = $clog2(FIFO_DEPTH) + 1;

  logic             sync1_q, sync2_q;
  logic             tick;
  logic             push_req, idle_evt;
  logic [7:0]       push_byte, head;
  logic             fifo_empty, fifo_full, push_ok, pop_ok;
  logic [LW-1:0]    fifo_level;
  logic             ie_q, to_q, sts_rx;
  logic [DUR_W-1:0] lim_q;
  logic             wr_status, wr_limit, rd_data, drained;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0; sync2_q <= 1'b0;
    end else begin
      sync1_q <= ir_in; sync2_q <= sync1_q;
    end
  end

  ir_tick_gen #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  ir_run_coder u_coder (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lvl_in(sync2_q), .idle_lim(lim_q),
    .emit(push_req), .emit_byte(push_byte), .idle_evt(idle_evt)
  );

  ir_sample_fifo #(.DEPTH(FIFO_DEPTH), .LW(LW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_req), .push_data(push_byte),
    .pop(rd_data), .head(head), .empty(fifo_empty), .full(fifo_full),
    .push_ok(push_ok), .pop_ok(pop_ok), .level(fifo_level)
  );

  assign wr_status = bus_sel && bus_wr && (bus_addr == OFS_STATUS);
  assign wr_limit  = bus_sel && bus_wr && (bus_addr == OFS_LIMIT);
  assign rd_data   = bus_sel && bus_rd && (bus_addr == OFS_DATA);
  assign drained   = pop_ok && (fifo_level == LW'(1)) && !push_ok;
  assign sts_rx    = !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      to_q  <= 1'b0;
      lim_q <= DUR_W'(IDLE_DEFAULT);
    end else begin
      if (wr_status) ie_q <= bus_wdata[7];
      if (wr_limit)  lim_q <= bus_wdata[DUR_W-1:0];
      if (idle_evt) to_q <= 1'b1;
      else if (drained) to_q <= 1'b0;
      else if (wr_status && bus_wdata[1] && fifo_empty) to_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_STATUS: bus_rdata = pack_status(ie_q, to_q, sts_rx);
      OFS_DATA:   bus_rdata = head;
      OFS_LIMIT:  bus_rdata = {1'b0, lim_q};
      default:    bus_rdata = 8'h00;
    endcase
  end

  assign irq = ie_q && (to_q || sts_rx);
endmodule

// File: rtl/ir_rx_checker.sv
module ir_rx_checker #(
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          ie,
  input logic          sts_rx,
  input logic          sts_to,
  input logic          irq,
  input logic          fifo_empty,
  input logic          fifo_full,
  input logic [LW-1:0] fifo_level,
  input logic          push_req,
  input logic          push_ok,
  input logic [7:0]    push_byte,
  input logic          pop_ok,
  input logic          idle_evt
);
  // R10
  irq_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie && !fifo_empty) |-> irq);

  // R7
  rx_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> sts_rx);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && fifo_full && !pop_ok) |=> $stable(fifo_level));

  // R1
  nonzero_dur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> (push_byte[6:0] != 7'd0));

  // R1
  emit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> tick);

  // R8
  drain_clears_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && fifo_level == LW'(1) && !push_ok && !idle_evt) |=> !sts_to);

  // R3
  timeout_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |=> sts_to);
endmodule

bind ir_rx_regs ir_rx_checker #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ie(ie_q), .sts_rx(sts_rx), .sts_to(to_q),
  .irq(irq), .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_level(fifo_level),
  .push_req(push_req), .push_ok(push_ok), .push_byte(push_byte), .pop_ok(pop_ok),
  .idle_evt(idle_evt)
);

// File: tb/sim_ir_rx_regs.sv
`timescale 1ns/1ps
module sim_ir_rx_regs;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_in = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ir_rx_regs #(.TICK_DIV(DIV), .FIFO_DEPTH(32), .IDLE_DEFAULT(20)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic drive(input logic lvl, input int ticks);
    @(negedge clk); ir_in = lvl;
    repeat (ticks * DIV - 1) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic expect_irq(input string req, input logic exp);
    @(negedge clk); #1 chk(req, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic t_reset;
    expect_reg("R11 status", 3'd0, 8'h00);
    expect_reg("R11 limit", 3'd4, 8'h14);
    expect_irq("R11 irq", 1'b0);
    expect_reg("R5 empty read", 3'd1, 8'h00);
    expect_reg("R11 other offset", 3'd2, 8'h00);
  endtask

  task automatic t_basic;
    wr(3'd0, 8'h80);
    drive(1, 5); drive(0, 3); drive(1, 7); drive(0, 30);
    expect_reg("R3 status after burst", 3'd0, 8'h83);
    expect_irq("R10 irq with data", 1'b1);
    expect_reg("R1 pulse 5", 3'd1, 8'h85);
    expect_reg("R1 space 3", 3'd1, 8'h03);
    expect_reg("R1 pulse 7", 3'd1, 8'h87);
    expect_reg("R7 still data", 3'd0, 8'h83);
    expect_reg("R3 timeout space", 3'd1, 8'h14);
    expect_reg("R8 drained", 3'd0, 8'h80);
    expect_irq("R10 irq after drain", 1'b0);
  endtask

  task automatic t_long_pulse;
    drive(1, 300); drive(0, 30);
    expect_reg("R2 split a", 3'd1, 8'hFF);
    expect_reg("R2 split b", 3'd1, 8'hFF);
    expect_reg("R2 remainder", 3'd1, 8'hAE);
    expect_reg("R3 timeout", 3'd1, 8'h14);
    expect_reg("R5 empty after", 3'd1, 8'h00);
  endtask

  task automatic t_enable_w1c;
    wr(3'd0, 8'h00);
    drive(1, 4); drive(0, 25);
    expect_reg("R9 status ie off", 3'd0, 8'h03);
    expect_irq("R10 irq gated", 1'b0);
    wr(3'd0, 8'h80);
    expect_irq("R10 irq enabled", 1'b1);
    wr(3'd0, 8'h83);
    expect_reg("R8 w1c ignored", 3'd0, 8'h83);
    wr(3'd0, 8'hFC);
    expect_reg("R9 tx bits zero", 3'd0, 8'h83);
    expect_reg("R1 pulse 4", 3'd1, 8'h84);
    expect_reg("R3 space", 3'd1, 8'h14);
    expect_reg("R8 cleared on drain", 3'd0, 8'h80);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 20; i++) begin
      drive(1, 1); drive(0, 1);
    end
    drive(0, 25);
    expect_reg("R6 status full", 3'd0, 8'h83);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] v;
      rd(3'd1, v);
      chk($sformatf("R6 entry %0d", i), v, (i % 2 == 0) ? 8'h81 : 8'h01);
    end
    expect_reg("R6 extra dropped", 3'd1, 8'h00);
    expect_reg("R7 empty status", 3'd0, 8'h80);
  endtask

  task automatic t_limit;
    wr(3'd4, 8'h05);
    expect_reg("R3 limit readback", 3'd4, 8'h05);
    drive(1, 3); drive(0, 10);
    expect_reg("R3 short status", 3'd0, 8'h83);
    expect_reg("R1 pulse 3", 3'd1, 8'h83);
    expect_reg("R3 short space", 3'd1, 8'h05);
  endtask

  task automatic t_no_timeout;
    wr(3'd4, 8'h00);
    drive(1, 2); drive(0, 140);
    @(negedge clk); ir_in = 1'b1;
    wr(3'd4, 8'h14);
    repeat (3 * DIV - 3) @(negedge clk);
    drive(0, 30);
    expect_reg("R4 pulse 2", 3'd1, 8'h82);
    expect_reg("R4 space split", 3'd1, 8'h7F);
    expect_reg("R4 space rest", 3'd1, 8'h0D);
    expect_reg("R1 pulse 3b", 3'd1, 8'h83);
    expect_reg("R3 restored limit", 3'd1, 8'h14);
    expect_reg("R8 final status", 3'd0, 8'h80);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_long_pulse();
    t_enable_w1c();
    t_overflow();
    t_limit();
    t_no_timeout();
    finish_run();
  end
endmodule